// File: doc/BRIEF.md
# Scaled-Index Address Adder

This execute-stage unit recognises the shift-and-add instructions of a 64-bit RISC-V-style core and computes their results. It takes a 32-bit instruction word and two register operand values. It reports whether the instruction is one of the scaled-add operations, and in that case it outputs the sum and the destination register index. A scaled-add operation shifts its first operand left by 1, 2 or 3 and then adds the second operand. It comes in two forms. The full-width form uses the whole first operand. The unsigned-word form uses only the low 32 bits of the first operand, zero-extended.

The bit-manipulation extension has an enable input. When that enable is low, a matching instruction produces an illegal-instruction flag and no result. Register file access, writeback, hazards and all other instructions are handled elsewhere.

An optional output register stage, selected by a parameter, adds one cycle of latency. It carries a valid bit that follows the valid bit at the input.

Top module: `scaled_add_unit`

## Requirements
- R1: An instruction with bits 31:25 = 0010000 and bits 6:0 = 0110011 is recognised when bits 14:12 are 010, 100 or 110, which select a shift of 1, 2 or 3. `match` rises and `result` = (rs1 << n) + rs2 over 64 bits.
- R2: With bits 6:0 = 0111011 and the same bits 31:25 and 14:12 coding, `result` = (zero-extended rs1[31:0] << n) + rs2. The upper 32 bits of rs1 have no effect on the result.
- R3: Any other value of bits 14:12 (000, 001, 011, 101, 111), any other value of bits 31:25, or any other opcode gives `match` = 0, `illegal` = 0 and `result` = 0.
- R4: A recognised instruction while `ext_en` = 0 gives `illegal` = 1, `match` = 0, `result` = 0 and `wb_en` = 0.
- R5: While `match` is 1, `rd` equals instruction bits 11:7, and `wb_en` is 1 exactly when that index is nonzero.
- R6: While `match` is 0, `result`, `rd` and `wb_en` are all 0.
- R7: The sum wraps modulo 2^64, and bits shifted above bit 63 are discarded.
- R8: With the output stage enabled, the outputs for an input presented in one cycle appear in the next cycle. `out_valid` copies `in_valid`, and `match` and `illegal` are 0 whenever `out_valid` is 0. `match` and `illegal` are never 1 together.
- R9: After reset, `out_valid`, `match`, `illegal` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | First operand (scaled) |
| rs2_val | input | XLEN | Second operand (added) |
| ext_en | input | 1 | Bit-manipulation extension enabled |
| out_valid | output | 1 | Output fields are valid |
| match | output | 1 | Legal scaled-add recognised |
| illegal | output | 1 | Scaled-add seen with extension disabled |
| result | output | XLEN | Computed sum, zero when no match |
| rd | output | 5 | Destination index, zero when no match |
| wb_en | output | 1 | Write back the result (match and rd nonzero) |

## Verification
The assertions assume that `in_valid`, `instr` and `ext_en` are known, two-state values whenever `rst_n` is high. They also assume that the instruction bits are ignored while `in_valid` is low. The stimulus drives every input on the falling clock edge and never leaves a field undriven. It holds `in_valid` low for the whole reset period, so the relations that look at the previous cycle start from a quiet state. The operands are random, but the opcode, funct7 and funct3 fields are chosen on purpose to cover every coding, both matching and non-matching.

// File: rtl/scaled_add_pkg.sv
package scaled_add_pkg;
  localparam logic [6:0] OPC_FULL  = 7'b0110011;
  localparam logic [6:0] OPC_UWORD = 7'b0111011;
  localparam logic [6:0] F7_SCALED = 7'b0010000;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_FULL  = 2'd1,
    FORM_UWORD = 2'd2
  } form_e;

  // funct3 -> shift amount; 0 means not a scaled-add coding
  function automatic logic [1:0] scale_of(input logic [2:0] f3);
    case (f3)
      3'b010:  scale_of = 2'd1;
      3'b100:  scale_of = 2'd2;
      3'b110:  scale_of = 2'd3;
      default: scale_of = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/scaled_add_decode.sv
module scaled_add_decode
  import scaled_add_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] instr,
  output logic        hit,
  output form_e       form,
  output logic [1:0]  shamt,
  output logic [4:0]  dst
);
  localparam bit WORD_OK = (XLEN == 64);

  logic       f7_ok;
  logic       is_full;
  logic       is_word;

  always_comb begin
    f7_ok   = (instr[31:25] == F7_SCALED);
    shamt   = scale_of(instr[14:12]);
    is_full = (instr[6:0] == OPC_FULL);
    is_word = WORD_OK && (instr[6:0] == OPC_UWORD);
    hit     = f7_ok && (shamt != 2'd0) && (is_full || is_word);
    if (!hit)         form = FORM_NONE;
    else if (is_word) form = FORM_UWORD;
    else              form = FORM_FULL;
    dst     = instr[11:7];
  end
endmodule

// File: rtl/scaled_add_datapath.sv
module scaled_add_datapath
  import scaled_add_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  form_e           form,
  input  logic [1:0]      shamt,
  output logic [XLEN-1:0] sum
);
  logic [XLEN-1:0] a_word;
  logic [XLEN-1:0] a_sel;

  function automatic logic [XLEN-1:0] scaled_sum(
    input logic [XLEN-1:0] a,
    input logic [XLEN-1:0] b,
    input logic [1:0]      n
  );
    scaled_sum = (a << n) + b;
  endfunction

  generate
    if (XLEN > 32) begin : g_zext
      assign a_word = {{(XLEN-32){1'b0}}, op_a[31:0]};
    end else begin : g_nozext
      assign a_word = op_a;
    end
  endgenerate

  always_comb begin
    a_sel = (form == FORM_UWORD) ? a_word : op_a;
    sum   = (form == FORM_NONE) ? '0 : scaled_sum(a_sel, op_b, shamt);
  end
endmodule

// File: rtl/scaled_add_unit.sv
module scaled_add_unit
  import scaled_add_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic            ext_en,
  output logic            out_valid,
  output logic            match,
  output logic            illegal,
  output logic [XLEN-1:0] result,
  output logic [4:0]      rd,
  output logic            wb_en
);
  // named internal events used by the checker
  logic            dec_hit;
  form_e           dec_form;
  logic [1:0]      dec_shamt;
  logic [4:0]      dec_dst;
  logic [XLEN-1:0] dp_sum;
  logic            nx_match;
  logic            nx_illegal;
  logic [XLEN-1:0] nx_result;
  logic [4:0]      nx_rd;
  logic            nx_wb;

  scaled_add_decode #(.XLEN(XLEN)) u_dec (
    .instr (instr),
    .hit   (dec_hit),
    .form  (dec_form),
    .shamt (dec_shamt),
    .dst   (dec_dst)
  );

  scaled_add_datapath #(.XLEN(XLEN)) u_dp (
    .op_a  (rs1_val),
    .op_b  (rs2_val),
    .form  (dec_form),
    .shamt (dec_shamt),
    .sum   (dp_sum)
  );

  always_comb begin
    nx_match   = in_valid && dec_hit && ext_en;
    nx_illegal = in_valid && dec_hit && !ext_en;
    nx_result  = nx_match ? dp_sum : '0;
    nx_rd      = nx_match ? dec_dst : 5'd0;
    nx_wb      = nx_match && (dec_dst != 5'd0);
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          match     <= 1'b0;
          illegal   <= 1'b0;
          result    <= '0;
          rd        <= 5'd0;
          wb_en     <= 1'b0;
        end else begin
          out_valid <= in_valid;
          match     <= nx_match;
          illegal   <= nx_illegal;
          result    <= nx_result;
          rd        <= nx_rd;
          wb_en     <= nx_wb;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign match     = nx_match;
      assign illegal   = nx_illegal;
      assign result    = nx_result;
      assign rd        = nx_rd;
      assign wb_en     = nx_wb;
    end
  endgenerate
endmodule

// File: rtl/scaled_add_unit_chk.sv
module scaled_add_unit_chk #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            ext_en,
  input logic            dec_hit,
  input logic            out_valid,
  input logic            match,
  input logic            illegal,
  input logic [XLEN-1:0] result,
  input logic [4:0]      rd,
  input logic            wb_en
);
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(match && illegal));

  assert_quiet_when_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!match && !illegal));

  assert_zero_when_nomatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> (result == '0 && rd == 5'd0 && !wb_en));

  assert_wb_needs_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (match && rd != 5'd0));

  assert_illegal_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en);

  generate
    if (REG_OUT) begin : g_seq
      assert_disabled_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_hit && !ext_en) |=> illegal);
      assert_enabled_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_hit && ext_en) |=> match);
      assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    end else begin : g_cmb
      assert_disabled_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_hit && !ext_en) |-> illegal);
      assert_enabled_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_hit && ext_en) |-> match);
    end
  endgenerate
endmodule

bind scaled_add_unit scaled_add_unit_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .ext_en    (ext_en),
  .dec_hit   (dec_hit),
  .out_valid (out_valid),
  .match     (match),
  .illegal   (illegal),
  .result    (result),
  .rd        (rd),
  .wb_en     (wb_en)
);

// File: tb/scaled_add_unit_test.sv
module scaled_add_unit_test;
  localparam int XLEN = 64;

  typedef struct {
    logic            v;
    logic            m;
    logic            il;
    logic [XLEN-1:0] res;
    logic [4:0]      rd;
    logic            wb;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] rs1_val = '0;
  logic [XLEN-1:0] rs2_val = '0;
  logic            ext_en = 1'b0;
  logic            out_valid, match, illegal, wb_en;
  logic [XLEN-1:0] result;
  logic [4:0]      rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  scaled_add_unit #(.XLEN(XLEN), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .ext_en(ext_en),
    .out_valid(out_valid), .match(match), .illegal(illegal),
    .result(result), .rd(rd), .wb_en(wb_en)
  );

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                     input logic [6:0] opc, input logic [4:0] d);
    mk = {f7, 5'd7, 5'd3, f3, d, opc};
  endfunction

  // reference: scaling as a multiplication
  function automatic logic [XLEN-1:0] ref_sum(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                              input int n, input bit word);
    logic [XLEN-1:0] aa;
    aa = word ? XLEN'(a[31:0]) : a;
    ref_sum = aa * (XLEN'(1) << n) + b;
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic en, input bit recog, input bit word, input int n, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; instr = ins; rs1_val = a; rs2_val = b; ext_en = en;
    e.v = 1'b1;
    e.m = recog && en;
    e.il = recog && !en;
    e.res = e.m ? ref_sum(a, b, n, word) : '0;
    e.rd = e.m ? ins[11:7] : 5'd0;
    e.wb = e.m && (ins[11:7] != 5'd0);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0; instr = mk(7'b0010000, 3'b010, 7'b0110011, 5'd9); ext_en = 1'b1;
    e.v = 0; e.m = 0; e.il = 0; e.res = '0; e.rd = 0; e.wb = 0; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: registered outputs compared 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk); #5;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (out_valid !== e.v || match !== e.m || illegal !== e.il || result !== e.res ||
            rd !== e.rd || wb_en !== e.wb) begin
          errors++;
          $display("FAIL %s: got v=%b m=%b il=%b res=%h rd=%0d wb=%b exp v=%b m=%b il=%b res=%h rd=%0d wb=%b",
                   e.tag, out_valid, match, illegal, result, rd, wb_en,
                   e.v, e.m, e.il, e.res, e.rd, e.wb);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f3s[3] = '{2, 4, 6};
    int bad3[5] = '{0, 1, 3, 5, 7};
    // R9: reset state
    #35;
    checks++;
    if (out_valid !== 1'b0 || match !== 1'b0 || illegal !== 1'b0 || wb_en !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: got v=%b m=%b il=%b wb=%b exp 0 0 0 0", out_valid, match, illegal, wb_en);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1 full form and R2 word form, random operands, all six encodings
    for (int k = 0; k < 3; k++) begin
      for (int t = 0; t < 20; t++) begin
        logic [XLEN-1:0] a, b;
        a = {$urandom, $urandom}; b = {$urandom, $urandom};
        drive(mk(7'b0010000, 3'(f3s[k]), 7'b0110011, 5'(1 + t)), a, b, 1, 1, 0, k + 1, "R1 full");
        drive(mk(7'b0010000, 3'(f3s[k]), 7'b0111011, 5'(2 + t)), a, b, 1, 1, 1, k + 1, "R2 word");
      end
    end
    // R2: upper rs1 bits set must not matter
    for (int k = 0; k < 3; k++)
      drive(mk(7'b0010000, 3'(f3s[k]), 7'b0111011, 5'd5), 64'hFFFF_FFFF_0000_0001, 64'd10, 1, 1, 1, k + 1, "R2 upper ignored");
    // R7: wrap and shift-out
    drive(mk(7'b0010000, 3'b110, 7'b0110011, 5'd4), 64'hFFFF_FFFF_FFFF_FFFF, 64'd9, 1, 1, 0, 3, "R7 wrap");
    drive(mk(7'b0010000, 3'b010, 7'b0110011, 5'd4), 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 1, "R7 shiftout");
    drive(mk(7'b0010000, 3'b110, 7'b0111011, 5'd4), 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFF8_0000_0008, 1, 1, 1, 3, "R7 word wrap");
    // R3: non-matching funct3, funct7, opcode
    for (int k = 0; k < 5; k++) begin
      drive(mk(7'b0010000, 3'(bad3[k]), 7'b0110011, 5'd6), 64'd3, 64'd4, 1, 0, 0, 0, "R3 funct3 full");
      drive(mk(7'b0010000, 3'(bad3[k]), 7'b0111011, 5'd6), 64'd3, 64'd4, 1, 0, 0, 0, "R3 funct3 word");
    end
    drive(mk(7'b0000000, 3'b010, 7'b0110011, 5'd6), 64'd3, 64'd4, 1, 0, 0, 0, "R3 funct7");
    drive(mk(7'b0010001, 3'b100, 7'b0110011, 5'd6), 64'd3, 64'd4, 1, 0, 0, 0, "R3 funct7 lsb");
    drive(mk(7'b0010000, 3'b100, 7'b0010011, 5'd6), 64'd3, 64'd4, 1, 0, 0, 0, "R3 opcode");
    // R4: extension disabled
    drive(mk(7'b0010000, 3'b010, 7'b0110011, 5'd8), 64'd3, 64'd4, 0, 1, 0, 1, "R4 disabled full");
    drive(mk(7'b0010000, 3'b110, 7'b0111011, 5'd8), 64'd3, 64'd4, 0, 1, 1, 3, "R4 disabled word");
    drive(mk(7'b0000000, 3'b000, 7'b0110011, 5'd8), 64'd3, 64'd4, 0, 0, 0, 0, "R4 disabled other");
    // R5: rd zero gives no writeback; rd 31
    drive(mk(7'b0010000, 3'b100, 7'b0110011, 5'd0), 64'd5, 64'd1, 1, 1, 0, 2, "R5 rd0");
    drive(mk(7'b0010000, 3'b100, 7'b0111011, 5'd31), 64'd5, 64'd1, 1, 1, 1, 2, "R5 rd31");
    // R8/R6: idle cycles between valid ones
    idle("R8 idle");
    drive(mk(7'b0010000, 3'b010, 7'b0110011, 5'd12), 64'd100, 64'd1, 1, 1, 0, 1, "R8 after idle");
    idle("R6 idle");
    idle("R8 idle2");
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R8 drain: got %0d pending exp 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule